// File: doc/BRIEF.md
# Serial memory command and write-protection front end

This block is the slave side of a four-wire serial link (clock idles low, data captured on the rising clock edge, next bit presented after the falling edge) for a small byte-wide memory with a supervisory timer. It runs on the system clock and oversamples the serial clock, select and data lines through a synchronizer. It decodes 8-bit command codes, holds a status byte, streams that byte or memory contents back to the master, and drives a simple array port (address, write data, write strobe, read strobe). The array is a registered memory with one cycle of read latency.

Before any array byte or status byte is written, the block checks a set of protection rules. These rules combine a volatile write-enable latch, a hardware write-protect pin that counts only when a stored enable bit is set, and a two-bit lock code that freezes the top quarter, the top half or all of the 2 KiB address space. The two timer-select bits are only presented on an output. The timer itself, the array and any nonvolatile storage are outside the block. Reset loads every status bit with zero.

Top module: `spi_memctl`

## Requirements
- R1: Command, address and data bytes are taken MSB first on rising serial-clock edges while select is low. Returned bytes appear MSB first, each bit presented after a falling edge.
- R2: Reset clears every status bit. Code 0x06 sets the write-enable latch (status bit 1). Code 0x04 clears it.
- R3: Code 0x00 sets the flag (status bit 6). Code 0x04 clears the flag together with the latch.
- R4: Code 0x05 returns the status byte {bit7 protect-enable, bit6 flag, bits5:4 timer select, bits3:2 lock code, bit1 latch, bit0 zero}. Each further byte clocked in the same selection repeats the status byte.
- R5: Code 0x01 followed by one byte loads bits 7, 5:4 and 3:2 of that byte. This happens only when the latch is 1 and the pair (protect-enable = 1, protect pin low) does not hold. Bits 6, 1 and 0 of the written byte never change the status.
- R6: Lock code 00 locks nothing, 01 locks 0x600–0x7FF, 10 locks 0x400–0x7FF and 11 locks every address. A byte aimed at a locked address is never strobed to the array.
- R7: An array byte is strobed only when the latch is 1. Unlocked addresses are writable whatever the protect-enable bit and the protect pin are.
- R8: Codes 0x03 (read) and 0x02 (write) take two address bytes, of which the low 11 bits are used. The address then steps by one per data byte and wraps from 0x7FF to 0x000.
- R9: When select rises after at least one complete data byte of a status write or array write, the latch clears, whether or not that byte was committed.
- R10: Raising select mid-byte discards the partial byte and restarts the bit count. A partial data byte commits nothing, and the latch is left as it was.
- R11: The timer-select output always equals status bits 5:4.
- R12: Any other command code changes no status bit and drives no array strobe.
- R13: The write strobe and the read strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from master, idles low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master, low when deselected |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | 8 | Array write data |
| arr_we | output | 1 | One-cycle array write strobe |
| arr_re | output | 1 | One-cycle array read strobe |
| arr_rdata | input | 8 | Array read data, valid the cycle after arr_re |
| wd_sel | output | 2 | Selected supervisory-timer period code |

## Verification
On every data byte of a write burst, the block decides whether that byte is protected and advances the address in the same clock cycle. A wrong ordering would judge a byte against its neighbour's address. The bench provokes this by starting a two-byte burst one address below the quarter-lock boundary. It expects exactly one strobe, and the first byte must read back. The same bursts also end with select rising soon after the last byte, so the final commit and the latch clear fall close together. The bench judges that the last byte still lands and that the latch then reads back as zero.

// File: rtl/spi_memctl_pkg.sv
package spi_memctl_pkg;
  localparam logic [7:0] OP_SETFLAG = 8'h00;
  localparam logic [7:0] OP_WRSR    = 8'h01;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_CLEAR   = 8'h04;
  localparam logic [7:0] OP_RDSR    = 8'h05;
  localparam logic [7:0] OP_WREN    = 8'h06;

  typedef enum logic [2:0] {
    ST_OPC, ST_AHI, ST_ALO, ST_WDATA, ST_RDATA, ST_SRRD, ST_SRWR, ST_SKIP
  } cmd_state_t;

  typedef struct packed {
    logic       wpen;
    logic       flag;
    logic [1:0] wd;
    logic [1:0] bl;
    logic       wel;
  } stat_t;

  function automatic logic [7:0] stat_byte(input stat_t s);
    return {s.wpen, s.flag, s.wd, s.bl, s.wel, 1'b0};
  endfunction
endpackage

// File: rtl/spi_memctl_sync.sv
module spi_memctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_act,
  output logic mosi_s
);
  localparam logic [2:0] IDLE_V = 3'b010;

  logic [STAGES-1:0][2:0] stg;
  logic [2:0] prev;
  logic [2:0] last;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= IDLE_V;
        else     stg[g] <= {sck, cs_n, mosi};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= IDLE_V;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign last = stg[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE_V;
    else     prev <= last;
  end

  assign sck_rise = last[2] & ~prev[2] & ~last[1];
  assign sck_fall = ~last[2] & prev[2];
  assign cs_rise  = last[1] & ~prev[1];
  assign cs_act   = ~last[1];
  assign mosi_s   = last[0];
endmodule

// File: rtl/spi_memctl_guard.sv
module spi_memctl_guard #(
  parameter int ADDR_W = 11
) (
  input  logic              wel,
  input  logic              wpen,
  input  logic              wp_n,
  input  logic [1:0]        bl,
  input  logic [ADDR_W-1:0] addr,
  output logic              arr_ok,
  output logic              sr_ok
);
  logic locked;

  always_comb begin
    unique case (bl)
      2'b00:   locked = 1'b0;
      2'b01:   locked = &addr[ADDR_W-1:ADDR_W-2];
      2'b10:   locked = addr[ADDR_W-1];
      default: locked = 1'b1;
    endcase
  end

  assign arr_ok = wel & ~locked;
  assign sr_ok  = wel & ~(wpen & ~wp_n);
endmodule

// File: rtl/spi_memctl.sv
module spi_memctl
  import spi_memctl_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              wp_n,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              arr_we,
  output logic              arr_re,
  input  logic [7:0]        arr_rdata,
  output logic [1:0]        wd_sel
);
  localparam int HI_W = ADDR_W - 8;

  logic sck_rise, sck_fall, cs_rise, cs_act, mosi_s;
  logic arr_ok, sr_ok;

  cmd_state_t        state;
  logic [2:0]        bit_cnt;
  logic [6:0]        rx_sh;
  logic [7:0]        tx_sh;
  logic [7:0]        byte_in;
  logic              byte_done;
  logic [HI_W-1:0]   addr_hi;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] new_addr;
  logic              rd_mode;
  logic              wr_seen;
  logic              ld_q;
  logic              miso_q;
  stat_t             st;

  spi_memctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
    .cs_act(cs_act), .mosi_s(mosi_s)
  );

  spi_memctl_guard #(.ADDR_W(ADDR_W)) u_guard (
    .wel(st.wel), .wpen(st.wpen), .wp_n(wp_n), .bl(st.bl), .addr(ptr),
    .arr_ok(arr_ok), .sr_ok(sr_ok)
  );

  assign byte_in   = {rx_sh, mosi_s};
  assign byte_done = sck_rise && (bit_cnt == 3'd7);
  assign new_addr  = {addr_hi, byte_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OPC;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      addr_hi   <= '0;
      ptr       <= '0;
      rd_mode   <= 1'b0;
      wr_seen   <= 1'b0;
      ld_q      <= 1'b0;
      miso_q    <= 1'b0;
      st        <= '0;
      arr_addr  <= '0;
      arr_wdata <= '0;
      arr_we    <= 1'b0;
      arr_re    <= 1'b0;
    end else begin
      arr_we <= 1'b0;
      arr_re <= 1'b0;
      ld_q   <= arr_re;
      if (ld_q) tx_sh <= arr_rdata;

      if (cs_rise) begin
        state   <= ST_OPC;
        bit_cnt <= '0;
        miso_q  <= 1'b0;
        wr_seen <= 1'b0;
        if (wr_seen) st.wel <= 1'b0;
      end else if (cs_act) begin
        if (sck_fall) begin
          miso_q <= tx_sh[7];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end
        if (sck_rise) begin
          rx_sh   <= byte_in[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_done) begin
          unique case (state)
            ST_OPC: begin
              state <= ST_SKIP;
              unique case (byte_in)
                OP_WREN:    st.wel  <= 1'b1;
                OP_SETFLAG: st.flag <= 1'b1;
                OP_CLEAR: begin
                  st.wel  <= 1'b0;
                  st.flag <= 1'b0;
                end
                OP_RDSR: begin
                  tx_sh <= stat_byte(st);
                  state <= ST_SRRD;
                end
                OP_WRSR: state <= ST_SRWR;
                OP_READ: begin
                  rd_mode <= 1'b1;
                  state   <= ST_AHI;
                end
                OP_WRITE: begin
                  rd_mode <= 1'b0;
                  state   <= ST_AHI;
                end
                default: state <= ST_SKIP;
              endcase
            end
            ST_AHI: begin
              addr_hi <= byte_in[HI_W-1:0];
              state   <= ST_ALO;
            end
            ST_ALO: begin
              if (rd_mode) begin
                arr_addr <= new_addr;
                ptr      <= new_addr + 1'b1;
                arr_re   <= 1'b1;
                state    <= ST_RDATA;
              end else begin
                ptr   <= new_addr;
                state <= ST_WDATA;
              end
            end
            ST_WDATA: begin
              arr_addr  <= ptr;
              arr_wdata <= byte_in;
              arr_we    <= arr_ok;
              ptr       <= ptr + 1'b1;
              wr_seen   <= 1'b1;
            end
            ST_RDATA: begin
              arr_addr <= ptr;
              ptr      <= ptr + 1'b1;
              arr_re   <= 1'b1;
            end
            ST_SRRD: tx_sh <= stat_byte(st);
            ST_SRWR: begin
              if (sr_ok) begin
                st.wpen <= byte_in[7];
                st.wd   <= byte_in[5:4];
                st.bl   <= byte_in[3:2];
              end
              wr_seen <= 1'b1;
              state   <= ST_SKIP;
            end
            default: state <= ST_SKIP;
          endcase
        end
      end
    end
  end

  assign spi_miso = miso_q;
  assign wd_sel   = st.wd;
endmodule

// File: rtl/spi_memctl_chk.sv
module spi_memctl_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              arr_we,
  input logic              arr_re,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              wel,
  input logic              wpen,
  input logic [1:0]        wd,
  input logic [1:0]        bl
);
  assert_we_re_excl_R13: assert property (@(posedge clk) disable iff (rst)
    !(arr_we && arr_re));

  assert_we_needs_wel_R7: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> wel);

  assert_lock_full_R6: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (bl != 2'b11));

  assert_lock_quarter_R6: assert property (@(posedge clk) disable iff (rst)
    (arr_we && bl == 2'b01) |-> (arr_addr[ADDR_W-1:ADDR_W-2] != 2'b11));

  assert_lock_half_R6: assert property (@(posedge clk) disable iff (rst)
    (arr_we && bl == 2'b10) |-> !arr_addr[ADDR_W-1]);

  assert_sr_needs_wel_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable({wpen, wd, bl}) |-> $past(wel));
endmodule

bind spi_memctl spi_memctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .arr_we(arr_we), .arr_re(arr_re), .arr_addr(arr_addr),
  .wel(st.wel), .wpen(st.wpen), .wd(st.wd), .bl(st.bl)
);

// File: tb/spi_memctl_bench.sv
module spi_memctl_bench;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          spi_sck = 1'b0;
  logic          spi_cs_n = 1'b1;
  logic          spi_mosi = 1'b0;
  logic          spi_miso;
  logic          wp_n = 1'b1;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_wdata;
  logic          arr_we;
  logic          arr_re;
  logic [7:0]    arr_rdata = 8'h00;
  logic [1:0]    wd_sel;

  int n_chk = 0;
  int n_fail = 0;
  int wr_count = 0;
  bit done = 1'b0;
  logic [7:0] mem [2**AW];

  always #4 clk = ~clk;

  spi_memctl u_spi_memctl (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .wp_n(wp_n),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_we(arr_we),
    .arr_re(arr_re), .arr_rdata(arr_rdata), .wd_sel(wd_sel)
  );

  always @(posedge clk) begin
    if (arr_we) begin
      mem[arr_addr] <= arr_wdata;
      wr_count <= wr_count + 1;
    end
    if (arr_re) arr_rdata <= mem[arr_addr];
  end

  // {status preset, wp_n, address, strobe expected, status after 0x00 write}
  localparam logic [28:0] VECS [10] = '{
    {8'h00, 1'b1, 11'h7FF, 1'b1, 8'h00},
    {8'h04, 1'b1, 11'h600, 1'b0, 8'h00},
    {8'h04, 1'b1, 11'h5FF, 1'b1, 8'h00},
    {8'h08, 1'b1, 11'h400, 1'b0, 8'h00},
    {8'h08, 1'b1, 11'h3FF, 1'b1, 8'h00},
    {8'h0C, 1'b1, 11'h000, 1'b0, 8'h00},
    {8'h84, 1'b0, 11'h123, 1'b1, 8'h84},
    {8'h84, 1'b0, 11'h700, 1'b0, 8'h84},
    {8'h80, 1'b1, 11'h7FF, 1'b1, 8'h00},
    {8'h34, 1'b0, 11'h650, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = tx[i];
      repeat (8) @(negedge clk);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      repeat (8) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    bits(tx, 8, rx);
  endtask

  task automatic cs_lo();
    spi_cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (8) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_lo(); xfer(op, d); cs_hi();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] d;
    cs_lo(); xfer(8'h05, d); xfer(8'h00, s); cs_hi();
  endtask

  task automatic wr_status(input logic [7:0] b);
    logic [7:0] d;
    cs_lo(); xfer(8'h01, d); xfer(b, d); cs_hi();
  endtask

  task automatic wr_head(input logic [AW-1:0] a);
    logic [7:0] d;
    cs_lo(); xfer(8'h02, d); xfer({5'b0, a[10:8]}, d); xfer(a[7:0], d);
  endtask

  task automatic rd_head(input logic [AW-1:0] a);
    logic [7:0] d;
    cs_lo(); xfer(8'h03, d); xfer({5'b0, a[10:8]}, d); xfer(a[7:0], d);
  endtask

  task automatic wr_arr(input logic [AW-1:0] a, input logic [7:0] v);
    logic [7:0] d;
    wr_head(a); xfer(v, d); cs_hi();
  endtask

  task automatic rd_arr(input logic [AW-1:0] a, output logic [7:0] v);
    rd_head(a); xfer(8'h00, v); cs_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, s2, d;
    int c0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // Reset state
    rd_status(s);
    chk("R2 reset status", s, 8'h00);
    chk("R11 reset timer select", wd_sel, 0);
    chk("R13 no strobes after reset", wr_count, 0);

    // Latch set, repeated status bytes, MSB first
    cmd1(8'h06);
    cs_lo(); xfer(8'h05, d); xfer(8'h00, s); xfer(8'h00, s2); cs_hi();
    chk("R1 R2 latch set status", s, 8'h02);
    chk("R4 repeated status byte", s2, 8'h02);

    // Flag and shared clear code
    cmd1(8'h00);
    rd_status(s);
    chk("R3 flag set", s, 8'h42);
    cmd1(8'h04);
    rd_status(s);
    chk("R3 R2 clear latch and flag", s, 8'h00);

    // Array write without latch
    c0 = wr_count;
    wr_arr(11'h010, 8'h11);
    chk("R7 write blocked without latch", wr_count - c0, 0);

    // Burst write, auto-increment, latch auto-clear
    cmd1(8'h06);
    c0 = wr_count;
    wr_head(11'h010); xfer(8'hA1, d); xfer(8'hA2, d); xfer(8'hA3, d); cs_hi();
    chk("R8 burst strobes", wr_count - c0, 3);
    rd_status(s);
    chk("R9 latch cleared after write", s, 8'h00);
    rd_head(11'h010); xfer(8'h00, s); xfer(8'h00, s2); xfer(8'h00, d); cs_hi();
    chk("R8 read byte 0", s, 8'hA1);
    chk("R8 read byte 1", s2, 8'hA2);
    chk("R8 read byte 2", d, 8'hA3);

    // Mid-byte abort
    cmd1(8'h06);
    c0 = wr_count;
    wr_head(11'h020); bits(8'hFF, 4, d); cs_hi();
    chk("R10 partial byte not strobed", wr_count - c0, 0);
    cs_lo(); bits(8'h00, 4, d); cs_hi();
    rd_status(s);
    chk("R10 latch kept and counter restarted", s, 8'h02);

    // Unknown codes
    cmd1(8'h00);
    c0 = wr_count;
    cmd1(8'hFF);
    cmd1(8'h9F);
    rd_status(s);
    chk("R12 unknown codes ignored", s, 8'h42);
    chk("R12 no strobe on unknown", wr_count - c0, 0);
    cmd1(8'h04);

    // Status write ignores bits 6, 1, 0
    cmd1(8'h06);
    wr_status(8'h43);
    rd_status(s);
    chk("R5 bits 6 1 0 not written", s, 8'h00);

    // Address wrap
    cmd1(8'h06);
    wr_head(11'h7FF); xfer(8'h5C, d); xfer(8'h5D, d); cs_hi();
    rd_arr(11'h000, s);
    chk("R8 address wraps to zero", s, 8'h5D);

    // Burst crossing the quarter-lock boundary
    cmd1(8'h06);
    wr_status(8'h04);
    cmd1(8'h06);
    c0 = wr_count;
    wr_head(11'h5FF); xfer(8'h77, d); xfer(8'h78, d); cs_hi();
    chk("R6 boundary burst one strobe", wr_count - c0, 1);
    rd_arr(11'h5FF, s);
    chk("R6 byte below boundary written", s, 8'h77);
    cmd1(8'h06);
    wr_status(8'h00);

    // Protection table
    for (int k = 0; k < 10; k++) begin
      logic [28:0] v;
      v = VECS[k];
      wp_n = 1'b1;
      cmd1(8'h06);
      wr_status(v[28:21]);
      rd_status(s);
      chk("R5 preset status", s, v[28:21] & 8'hBC);
      chk("R11 timer select follows status", wd_sel, v[26:25]);
      wp_n = v[20];
      cmd1(8'h06);
      c0 = wr_count;
      wr_arr(v[19:9], v[16:9] ^ 8'h5A);
      chk("R6 R7 strobe decision", wr_count - c0, v[8]);
      if (v[8]) begin
        rd_arr(v[19:9], s);
        chk("R8 table readback", s, v[16:9] ^ 8'h5A);
      end
      cmd1(8'h06);
      wr_status(8'h00);
      rd_status(s);
      chk("R5 protected status write", s, v[7:0]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule